// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block produces the two clocks an audio serial port needs, a master clock for the external converter and a bit clock for the serial data, from one of several source clocks picked by a select input. Each output has its own divisor. A non-zero divisor D gives an output at the source frequency divided by 2·D, with a 50% duty cycle. A divisor of zero hands the source straight through.

The design runs entirely on one fast reference clock. Each source clock arrives as a slow level input. The block samples the selected source, finds its edges and drives both outputs as registered square waves. Single-cycle command pulses start the dividers, stop them, or stop them and clear their state. A status output shows whether the dividers are running. A separate enable decides whether the master clock leaves the block at all. A new divisor never cuts a period short. It is loaded only at the point where the output would begin a fresh low phase.

Top module: `aclk_gen`

## Requirements
- R1: With master divisor M > 0 and selected source period P reference cycles, `mclk` is high for exactly M·P cycles and low for exactly M·P cycles.
- R2: With bit divisor B > 0, `bclk` is high for B·P and low for B·P cycles, independently of the master divisor.
- R3: A divisor of 0 makes that output follow the selected source, high P/2 and low P/2 for a symmetric source.
- R4: Divisors are DIV_W = 6 bits wide, and the largest value, 63, gives high and low phases of 63·P cycles.
- R5: `src_sel` picks bit `src_sel` of `src_clk` as the source. Index 0 is the peripheral clock and index 1 is the generated clock.
- R6: While `mck_en` is 0, `mclk` stays low and `bclk` keeps toggling.
- R7: After reset, `running`, `mclk` and `bclk` are 0. A `clk_en` pulse sets `running` at the next edge. A `clk_dis` pulse clears it. While stopped, both outputs are low.
- R8: When `clk_en` and `clk_dis` are high in the same cycle, `running` is 0 afterwards.
- R9: A `soft_rst` pulse clears `running` and returns both outputs low, whatever `clk_en` does in that cycle.
- R10: After an enable, each output starts low.
- R11: A divisor written during a high phase is loaded only when that phase ends. The running high phase keeps its old length, and the low phase that follows uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | N_SRC | Source clock levels, index 0 peripheral, 1 generated |
| src_sel | input | SEL_W | Source index |
| mck_div | input | DIV_W | Master clock divisor, 0 = pass-through |
| bck_div | input | DIV_W | Bit clock divisor, 0 = pass-through |
| mck_en | input | 1 | Drive the master clock out |
| clk_en | input | 1 | One-cycle start command |
| clk_dis | input | 1 | One-cycle stop command |
| soft_rst | input | 1 | One-cycle stop-and-clear command |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| running | output | 1 | Dividers active |

## Verification
The checker assumes that the commands are single-cycle pulses and that `mck_en` changes only with one clean cycle of settling. Its stop-state properties therefore look back only one cycle. The dividers assume each source is much slower than the reference, at least two reference cycles per period, and that the select changes only while stopped. The bench generates its sources from reference-cycle counters with half periods of at least one cycle. It changes `src_sel` only between a disable and the next enable.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
   // Edge events of the selected source, seen in the reference domain
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } src_evt_t;

   typedef enum logic [1:0] {
      RUN_HOLD  = 2'd0,
      RUN_START = 2'd1,
      RUN_STOP  = 2'd2
   } run_cmd_t;
endpackage

// File: rtl/aclk_src_pick.sv
module aclk_src_pick
   import aclk_pkg::*;
#(
   parameter int N_SRC       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_clk,
   input  logic [SEL_W-1:0] src_sel,
   output src_evt_t         evt
);
   logic picked;
   logic lvl_q;
   logic prev_q;

   assign picked = src_clk[src_sel];

   generate
      if (SYNC_STAGES <= 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= picked;
         end
      end else begin : g_chain
         logic [SYNC_STAGES-2:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
               lvl_q   <= 1'b0;
            end else begin
               if (SYNC_STAGES == 2) chain_q[0] <= picked;
               else chain_q <= {chain_q[SYNC_STAGES-3:0], picked};
               lvl_q <= chain_q[SYNC_STAGES-2];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_q;
   end

   always_comb begin
      evt.lvl  = lvl_q;
      evt.rise = lvl_q & ~prev_q;
      evt.fall = ~lvl_q & prev_q;
   end
endmodule

// File: rtl/aclk_run_ctl.sv
module aclk_run_ctl
   import aclk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clk_en,
   input  logic clk_dis,
   input  logic soft_rst,
   output logic run
);
   run_cmd_t cmd;

   always_comb begin
      if (soft_rst || clk_dis) cmd = RUN_STOP;
      else if (clk_en)         cmd = RUN_START;
      else                     cmd = RUN_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else begin
         case (cmd)
            RUN_STOP:  run <= 1'b0;
            RUN_START: run <= 1'b1;
            default:   run <= run;
         endcase
      end
   end
endmodule

// File: rtl/aclk_div.sv
module aclk_div
   import aclk_pkg::*;
#(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  src_evt_t         evt,
   input  logic [DIV_W-1:0] div_in,
   output logic             clk_out
);
   logic [DIV_W-1:0] div_act;
   logic [DIV_W-1:0] cnt;
   logic             last_rise;

   assign last_rise = (cnt == div_act - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_out <= 1'b0;
         cnt     <= '0;
         div_act <= '0;
      end else if (!run) begin
         clk_out <= 1'b0;
         cnt     <= '0;
         div_act <= div_in;
      end else if (div_act == '0) begin
         // pass-through: rise only on a source rise, boundary at source fall
         if (evt.rise) clk_out <= 1'b1;
         else if (evt.fall) begin
            clk_out <= 1'b0;
            cnt     <= '0;
            div_act <= div_in;
         end
      end else if (evt.rise) begin
         if (last_rise) begin
            cnt     <= '0;
            clk_out <= ~clk_out;
            if (clk_out) div_act <= div_in;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
   import aclk_pkg::*;
#(
   parameter int N_SRC       = 2,
   parameter int DIV_W       = 6,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_clk,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [DIV_W-1:0] mck_div,
   input  logic [DIV_W-1:0] bck_div,
   input  logic             mck_en,
   input  logic             clk_en,
   input  logic             clk_dis,
   input  logic             soft_rst,
   output logic             mclk,
   output logic             bclk,
   output logic             running
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("aclk_gen: N_SRC must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("aclk_gen: DIV_W must be at least 1");
      end
   endgenerate

   src_evt_t evt;
   logic     run;
   logic     mck_run;

   aclk_src_pick #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_pick (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src_sel(src_sel), .evt(evt)
   );

   aclk_run_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_dis(clk_dis),
      .soft_rst(soft_rst), .run(run)
   );

   assign mck_run = run & mck_en;

   aclk_div #(.DIV_W(DIV_W)) u_mdiv (
      .clk(clk), .rst_n(rst_n), .run(mck_run), .evt(evt),
      .div_in(mck_div), .clk_out(mclk)
   );

   aclk_div #(.DIV_W(DIV_W)) u_bdiv (
      .clk(clk), .rst_n(rst_n), .run(run), .evt(evt),
      .div_in(bck_div), .clk_out(bclk)
   );

   assign running = run;
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic clk_en,
   input logic clk_dis,
   input logic soft_rst,
   input logic mck_en,
   input logic mclk,
   input logic bclk,
   input logic running
);
   a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !clk_dis && !soft_rst) |=> running);

   a_r8_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clk_dis |=> !running);

   a_r9_soft_stop: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !running);

   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && $past(!running)) |-> (!mclk && !bclk));

   a_r6_mclk_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!mck_en && $past(!mck_en)) |-> !mclk);
endmodule

bind aclk_gen aclk_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_dis(clk_dis),
   .soft_rst(soft_rst), .mck_en(mck_en), .mclk(mclk), .bclk(bclk),
   .running(running)
);

// File: tb/aclk_gen_bench.sv
`timescale 1ns/1ps
module aclk_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_clk = 2'b00;
   logic       src_sel = 1'b0;
   logic [5:0] mck_div = 6'd0;
   logic [5:0] bck_div = 6'd0;
   logic       mck_en = 1'b0;
   logic       clk_en = 1'b0;
   logic       clk_dis = 1'b0;
   logic       soft_rst = 1'b0;
   logic       mclk, bclk, running;

   int n_chk = 0;
   int n_bad = 0;
   int half0 = 3;
   int half1 = 5;
   int c0 = 0;
   int c1 = 0;

   always #10 clk = ~clk;

   aclk_gen u_aclk_gen (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src_sel(src_sel),
      .mck_div(mck_div), .bck_div(bck_div), .mck_en(mck_en),
      .clk_en(clk_en), .clk_dis(clk_dis), .soft_rst(soft_rst),
      .mclk(mclk), .bclk(bclk), .running(running)
   );

   // source generators, counted in reference cycles
   always @(negedge clk) begin
      if (c0 + 1 >= half0) begin c0 <= 0; src_clk[0] <= ~src_clk[0]; end
      else c0 <= c0 + 1;
      if (c1 + 1 >= half1) begin c1 <= 0; src_clk[1] <= ~src_clk[1]; end
      else c1 <= c1 + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic sigv(input int which);
      return (which == 0) ? mclk : bclk;
   endfunction

   task automatic pulse(input bit en, input bit dis, input bit rst);
      @(negedge clk);
      clk_en = en; clk_dis = dis; soft_rst = rst;
      @(negedge clk);
      clk_en = 1'b0; clk_dis = 1'b0; soft_rst = 1'b0;
   endtask

   // wait for a rise of the output, optionally change bck_div, then time both phases
   task automatic meas(input int which, input int new_bdiv, output int hi, output int lo);
      int guard;
      logic prev;
      hi = 0; lo = 0; guard = 0;
      @(negedge clk);
      prev = sigv(which);
      forever begin
         @(negedge clk);
         guard++;
         if (sigv(which) && !prev) break;
         prev = sigv(which);
         if (guard > 5000) begin hi = -1; return; end
      end
      if (new_bdiv >= 0) bck_div = new_bdiv[5:0];
      while (sigv(which) && hi < 5000) begin hi++; @(negedge clk); end
      while (!sigv(which) && lo < 5000) begin lo++; @(negedge clk); end
   endtask

   task automatic restart();
      pulse(1'b0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      pulse(1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      check(mclk == 0 && bclk == 0, "R7 reset outputs", {mclk, bclk}, 0);
      check(running == 0, "R7 reset running", running, 0);
   endtask

   task automatic t_divide();
      int hi, lo;
      src_sel = 0; half0 = 3; mck_div = 3; bck_div = 2; mck_en = 1;
      @(negedge clk);
      clk_en = 1;
      @(negedge clk);
      clk_en = 0;
      check(running == 1, "R7 enable sets running", running, 1);
      check(mclk == 0 && bclk == 0, "R10 start low", {mclk, bclk}, 0);
      meas(0, -1, hi, lo);
      check(hi == 18, "R1 mclk high", hi, 18);
      check(lo == 18, "R1 mclk low", lo, 18);
      meas(1, -1, hi, lo);
      check(hi == 12, "R2 bclk high", hi, 12);
      check(lo == 12, "R2 bclk low", lo, 12);
   endtask

   task automatic t_bypass();
      int hi, lo;
      bck_div = 0;
      restart();
      meas(1, -1, hi, lo);
      check(hi == 3, "R3 pass-through high", hi, 3);
      check(lo == 3, "R3 pass-through low", lo, 3);
   endtask

   task automatic t_max();
      int hi, lo;
      pulse(1'b0, 1'b1, 1'b0);
      half0 = 1; mck_div = 63;
      repeat (3) @(negedge clk);
      pulse(1'b1, 1'b0, 1'b0);
      meas(0, -1, hi, lo);
      check(hi == 126, "R4 max divisor high", hi, 126);
      check(lo == 126, "R4 max divisor low", lo, 126);
   endtask

   task automatic t_select();
      int hi, lo;
      pulse(1'b0, 1'b1, 1'b0);
      src_sel = 1; half1 = 5; bck_div = 2;
      repeat (3) @(negedge clk);
      pulse(1'b1, 1'b0, 1'b0);
      meas(1, -1, hi, lo);
      check(hi == 20, "R5 generated source high", hi, 20);
      check(lo == 20, "R5 generated source low", lo, 20);
   endtask

   task automatic t_mck_off();
      int hi, lo;
      int seen;
      seen = 0;
      mck_en = 0;
      repeat (300) begin
         @(negedge clk);
         if (mclk) seen++;
      end
      check(seen == 0, "R6 mclk held low", seen, 0);
      meas(1, -1, hi, lo);
      check(hi == 20, "R6 bclk still toggles", hi, 20);
      mck_en = 1;
   endtask

   task automatic t_stop();
      @(negedge clk);
      clk_dis = 1;
      @(negedge clk);
      clk_dis = 0;
      check(running == 0, "R7 disable clears running", running, 0);
      repeat (2) @(negedge clk);
      check(mclk == 0 && bclk == 0, "R7 stopped outputs low", {mclk, bclk}, 0);
   endtask

   task automatic t_both();
      pulse(1'b1, 1'b1, 1'b0);
      check(running == 0, "R8 both from stopped", running, 0);
      pulse(1'b1, 1'b0, 1'b0);
      check(running == 1, "R8 started", running, 1);
      pulse(1'b1, 1'b1, 1'b0);
      check(running == 0, "R8 both from running", running, 0);
   endtask

   task automatic t_srst();
      src_sel = 0; half0 = 3; bck_div = 1;
      pulse(1'b1, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      pulse(1'b1, 1'b0, 1'b1);
      check(running == 0, "R9 soft reset stops", running, 0);
      @(negedge clk);
      check(mclk == 0 && bclk == 0, "R9 outputs cleared", {mclk, bclk}, 0);
   endtask

   task automatic t_change();
      int hi, lo;
      bck_div = 2;
      pulse(1'b1, 1'b0, 1'b0);
      meas(1, 4, hi, lo);
      check(hi == 12, "R11 old high phase kept", hi, 12);
      check(lo == 24, "R11 new low phase", lo, 24);
      meas(1, -1, hi, lo);
      check(hi == 24, "R11 new high phase", hi, 24);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1;
      repeat (3) @(negedge clk);
      t_reset();
      t_divide();
      t_bypass();
      t_max();
      t_select();
      t_mck_off();
      t_stop();
      t_both();
      t_srst();
      t_change();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule